// File: doc/BRIEF.md
# Set/Clear General-Purpose I/O Port

This block is a memory-mapped general-purpose I/O port, 32 pins wide by default. Each pin has an output value and an output-enable. Software never writes either of them as a whole word. It writes ones into a set location or a clear location instead, and only the pins whose write-data bit is one change. A single pin can therefore be driven, released or toggled without first reading the register and writing it back. The mode of access lets bit-banged serial buses, such as a management clock and a bidirectional data line, share one port with unrelated pins.

The bus side is a plain register port. It has a byte address, write data, a write strobe that acts on the rising clock edge, and combinational read data. The pin side presents the output value and the drive enable for each pin. Each pin's input level passes through a synchronizer before software can read it.

Top module: `setclr_gpio_port`

## Requirements
- R1: While reset is high at a rising edge, every output value bit and every enable bit is 0 after that edge, so every pin is released to high impedance.
- R2: A write at byte address 0x00 sets to 1 each output value bit `n` for which write-data bit `n` is 1. Output value bits written as 0 keep their value.
- R3: A write at byte address 0x10 sets to 0 each output value bit `n` for which write-data bit `n` is 1. Output value bits written as 0 keep their value.
- R4: A write at byte address 0x20 sets to 1 each enable bit written as 1, which turns on the driver of that pin. Other enable bits keep their value.
- R5: A write at byte address 0x30 sets to 0 each enable bit written as 1, which puts that pin in high impedance. Other enable bits keep their value.
- R6: A read at byte address 0x40 returns the pin input levels, bit `n` for pin `n`. A change on the pins first appears there after the second rising edge that follows it.
- R7: A read at byte address 0x00 or 0x10 returns the current output value register. A read at 0x20 or 0x30 returns the current enable register.
- R8: A write to any other address, 0x40 included, changes neither output values nor enables. A read at any address other than 0x00, 0x10, 0x20, 0x30 and 0x40 returns all zeros.
- R9: While the write strobe is low, output values and enables hold their state whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | WIDTH | Write data; bit n selects pin n |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| pin_out | output | WIDTH | Output value per pin |
| pin_oe | output | WIDTH | Output driver enable per pin; 0 means high impedance |
| pin_in | input | WIDTH | Input level per pin (asynchronous) |

## Verification
The bench builds the port with WIDTH set to 8 and keeps the default two-stage synchronizer and 8-bit address. At 8 bits every write pattern can be applied to each of the four set and clear locations from a mixed starting state. Every input pattern can also be stepped through the synchronizer and checked at both edges of its two-edge latency. The narrow width also leaves room for sweeping the unmapped addresses in the 8-bit space for both reads and writes.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;

    // Byte offsets that software relies on
    localparam logic [7:0] OFS_OUT_SET = 8'h00;
    localparam logic [7:0] OFS_OUT_CLR = 8'h10;
    localparam logic [7:0] OFS_OE_SET  = 8'h20;
    localparam logic [7:0] OFS_OE_CLR  = 8'h30;
    localparam logic [7:0] OFS_PINS    = 8'h40;

    typedef enum logic [2:0] {
        SEL_OUT_SET,
        SEL_OUT_CLR,
        SEL_OE_SET,
        SEL_OE_CLR,
        SEL_PINS,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic out_set;
        logic out_clr;
        logic oe_set;
        logic oe_clr;
    } wr_strobe_t;

    function automatic wr_strobe_t strobes_for(reg_sel_e sel, logic we);
        wr_strobe_t s;
        s.out_set = we && (sel == SEL_OUT_SET);
        s.out_clr = we && (sel == SEL_OUT_CLR);
        s.oe_set  = we && (sel == SEL_OE_SET);
        s.oe_clr  = we && (sel == SEL_OE_CLR);
        return s;
    endfunction

endpackage

// File: rtl/sc_gpio_bitreg.sv
module sc_gpio_bitreg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        q_next = q;
        if (set_en) begin
            q_next = q | mask;
        end else if (clr_en) begin
            q_next = q & ~mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    // R2 / R4: every masked bit reads one after a set write
    p_set_hits_r2: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & $past(mask)) == $past(mask)));

    // R3 / R5: every masked bit reads zero after a clear write
    p_clr_hits_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((q & $past(mask)) == '0));

    // R2 / R3: unmasked bits keep their value on any write
    p_unmasked_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (set_en || clr_en) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));

    // R9: no strobe, no change
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/sc_gpio_sync.sv
module sc_gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= '0;
            end
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] age;
            always_ff @(posedge clk) begin
                if (rst) begin
                    age <= '0;
                end else if (age != 2'd3) begin
                    age <= age + 2'd1;
                end
            end
            // R6: readback equals the pin level from two edges earlier
            p_sync_delay_r6: assert property (@(posedge clk) disable iff (rst)
                (age >= 2'd2) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/setclr_gpio_port.sv
module setclr_gpio_port
    import sc_gpio_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic [WIDTH-1:0]  pin_in
);

    localparam int OFS_W = (ADDR_W < 8) ? ADDR_W : 8;

    function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
        logic [ADDR_W-1:0] ext;
        ext = '0;
        ext[OFS_W-1:0] = ofs[OFS_W-1:0];
        return a == ext;
    endfunction

    reg_sel_e         sel;
    wr_strobe_t       stb;
    logic [WIDTH-1:0] pins_sync;

    always_comb begin
        if (hit(bus_addr, OFS_OUT_SET)) begin
            sel = SEL_OUT_SET;
        end else if (hit(bus_addr, OFS_OUT_CLR)) begin
            sel = SEL_OUT_CLR;
        end else if (hit(bus_addr, OFS_OE_SET)) begin
            sel = SEL_OE_SET;
        end else if (hit(bus_addr, OFS_OE_CLR)) begin
            sel = SEL_OE_CLR;
        end else if (hit(bus_addr, OFS_PINS)) begin
            sel = SEL_PINS;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign stb = strobes_for(sel, bus_we);

    sc_gpio_bitreg #(.WIDTH(WIDTH)) u_out_reg (
        .clk    (clk),
        .rst    (rst),
        .set_en (stb.out_set),
        .clr_en (stb.out_clr),
        .mask   (bus_wdata),
        .q      (pin_out)
    );

    sc_gpio_bitreg #(.WIDTH(WIDTH)) u_oe_reg (
        .clk    (clk),
        .rst    (rst),
        .set_en (stb.oe_set),
        .clr_en (stb.oe_clr),
        .mask   (bus_wdata),
        .q      (pin_oe)
    );

    sc_gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pins_sync)
    );

    always_comb begin
        case (sel)
            SEL_OUT_SET, SEL_OUT_CLR: bus_rdata = pin_out;
            SEL_OE_SET, SEL_OE_CLR:   bus_rdata = pin_oe;
            SEL_PINS:                 bus_rdata = pins_sync;
            default:                  bus_rdata = '0;
        endcase
    end

    // R1: reset releases every pin and zeroes every output value
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> ((pin_out == '0) && (pin_oe == '0)));

    // R7: set/clear locations read back the register they act on
    p_read_out_r7: assert property (@(posedge clk) disable iff (rst)
        (hit(bus_addr, OFS_OUT_SET) || hit(bus_addr, OFS_OUT_CLR)) |-> (bus_rdata == pin_out));
    p_read_oe_r7: assert property (@(posedge clk) disable iff (rst)
        (hit(bus_addr, OFS_OE_SET) || hit(bus_addr, OFS_OE_CLR)) |-> (bus_rdata == pin_oe));

    // R8: writes outside the four write locations leave the pins alone
    p_stray_write_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !hit(bus_addr, OFS_OUT_SET) && !hit(bus_addr, OFS_OUT_CLR)
                && !hit(bus_addr, OFS_OE_SET)  && !hit(bus_addr, OFS_OE_CLR))
        |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/setclr_gpio_port_bench.sv
module setclr_gpio_port_bench;

    localparam int W = 8;
    localparam int A = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [A-1:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic [W-1:0] pin_in = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    setclr_gpio_port #(.WIDTH(W), .ADDR_W(A), .SYNC_STAGES(2)) u_setclr_gpio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [A-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [A-1:0] a, output logic [W-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] base;
        logic [W-1:0] prev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 out after reset", pin_out, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);
        rd(8'h00, v); check("R1 out readback", v, 8'h00);

        // R2 / R3 / R7: output value sweep
        base = 8'h5A;
        for (int i = 0; i < 256; i++) begin
            wr(8'h10, 8'hFF); wr(8'h00, base);
            wr(8'h00, W'(i));
            check("R2 set output", pin_out, base | W'(i));
            rd(8'h10, v); check("R7 read at 0x10", v, base | W'(i));
            wr(8'h10, W'(i));
            check("R3 clear output", pin_out, (base | W'(i)) & ~W'(i));
            rd(8'h00, v); check("R7 read at 0x00", v, (base | W'(i)) & ~W'(i));
            check("R2 enables untouched", pin_oe, 8'h00);
        end

        // R4 / R5 / R7: enable sweep
        wr(8'h00, 8'hFF); wr(8'h10, 8'h3C);
        base = 8'hA3;
        for (int i = 0; i < 256; i++) begin
            wr(8'h30, 8'hFF); wr(8'h20, base);
            wr(8'h20, W'(i));
            check("R4 enable drive", pin_oe, base | W'(i));
            rd(8'h30, v); check("R7 read at 0x30", v, base | W'(i));
            wr(8'h30, W'(i));
            check("R5 release to hi-z", pin_oe, (base | W'(i)) & ~W'(i));
            rd(8'h20, v); check("R7 read at 0x20", v, (base | W'(i)) & ~W'(i));
            check("R4 outputs untouched", pin_out, 8'hC3);
        end

        // R6: two-edge synchronizer latency on every pattern
        prev = pin_in;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            logic [W-1:0] nv;
            nv = W'(i * 37 + 11);
            @(negedge clk);
            pin_in = nv; bus_addr = 8'h40; bus_we = 1'b0;
            @(negedge clk); #1
            check("R6 one edge later still old", bus_rdata, prev);
            @(negedge clk); #1
            check("R6 two edges later new", bus_rdata, nv);
            prev = nv;
        end

        // R8: stray writes and unmapped reads
        wr(8'h10, 8'hFF); wr(8'h00, 8'h96);
        wr(8'h30, 8'hFF); wr(8'h20, 8'h69);
        for (int a = 0; a < 256; a++) begin
            logic [A-1:0] ad;
            ad = A'(a);
            if (ad != 8'h00 && ad != 8'h10 && ad != 8'h20 && ad != 8'h30) begin
                wr(ad, 8'hFF);
                wr(ad, 8'h00);
                check("R8 stray write out", pin_out, 8'h96);
                check("R8 stray write oe", pin_oe, 8'h69);
                if (ad != 8'h40) begin
                    rd(ad, v); check("R8 unmapped read", v, 8'h00);
                end
            end
        end

        // R9: strobe low holds state for every location
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bus_addr = A'(k * 16); bus_wdata = (k % 2 == 0) ? 8'hFF : 8'h00;
            bus_we = 1'b0;
            repeat (3) @(negedge clk);
            bus_wdata = ~bus_wdata;
            repeat (2) @(negedge clk);
            check("R9 idle out hold", pin_out, 8'h96);
            check("R9 idle oe hold", pin_oe, 8'h69);
        end

        // R1: reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 out after mid reset", pin_out, 8'h00);
        check("R1 oe after mid reset", pin_oe, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule